// File: doc/BRIEF.md
# Instruction Loop Cache Controller

This block sits between instruction fetch and decode. It lets a short loop body run many times while fetching it only once. When decode sees a loop-start instruction, it raises a strobe together with two fields: a word count N and an iteration count K.

- **Load (N nonzero).** The next N fetched words go to the output as usual and are also written into a small on-chip buffer. If more than one iteration is wanted, the block then raises a stall toward fetch. It replays the buffered words from the buffer for the remaining iterations. When it finishes, it tells fetch to carry on at the address just after the last buffered word.
- **Redo (N zero).** The words already in the buffer are replayed K times. Nothing is fetched during the redo.
- **Iteration count.** A zero K takes the count from a separate loop-count input instead.

Outside a loop, every fetched word passes straight through, one cycle later. A busy flag covers the whole loop operation, from the strobe until the last word has been issued.

Top module: `loop_cache_ctrl`

## Requirements
- R1: Outside a loop, a fetch word presented with fetch_valid_i appears on instr_o with instr_valid_o high in the following cycle.
- R2: With a nonzero N, the N fetch words accepted after the strobe are passed to instr_o one cycle after acceptance and are stored in order.
- R3: With an effective iteration count above one, stall_o is high from the cycle after the N-th word is accepted. The stored words are then issued in order for the remaining iterations. Any fetch word presented while stall_o is high is ignored.
- R4: A zero K uses loop_count_i as the iteration count. If loop_count_i is also zero, the loop runs exactly one pass.
- R5: A zero N replays the stored words K times from the buffer, with stall_o high from the cycle after the strobe and no redirect. If no words have ever been stored, the strobe does nothing and busy_o stays low.
- R6: After a loaded loop with more than one iteration, redirect_o pulses for one cycle. The pulse comes in the cycle busy_o falls, and redirect_addr_o carries the last stored word's address plus one.
- R7: busy_o is high from the cycle after an accepted strobe. It falls in the cycle after the final word of the final pass appeared on instr_o, and stall_o falls with it.
- R8: A strobe arriving while busy_o is high is ignored. The running loop and the stored word count are unchanged.
- R9: With an effective iteration count of one, stall_o stays low and redirect_o does not pulse.
- R10: N may take any value up to the buffer depth of 15. A 15-word loop replays all 15 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | Fetch word present |
| fetch_addr_i | input | 12 | Address of the fetch word |
| fetch_data_i | input | 16 | Fetch word |
| loop_start_i | input | 1 | Decoded loop-start strobe |
| loop_n_i | input | 4 | Word count N, zero means redo |
| loop_k_i | input | 7 | Iteration count K, zero means use loop_count_i |
| loop_count_i | input | 7 | Loop-count register value |
| instr_o | output | 16 | Issued instruction word |
| instr_valid_o | output | 1 | instr_o holds a word this cycle |
| stall_o | output | 1 | Fetch must hold |
| busy_o | output | 1 | Loop operation in progress |
| redirect_o | output | 1 | One-cycle pulse: fetch resumes at redirect_addr_o |
| redirect_addr_o | output | 12 | Resume address after a replayed load |

## Verification
The block's results fall due at fixed distances from the stimulus:

- A passed-through or captured word shows on instr_o one cycle after it is accepted.
- A replayed word shows two cycles after it is issued from the buffer, because the read is registered.
- stall_o rises the cycle after the last capture, or the cycle after a redo strobe.
- busy_o falls in the cycle after the last output, with the redirect pulse in that same cycle.

Inputs are driven and outputs sampled on the falling edge. An ordered scoreboard compares each valid output with the next queued word, whatever its cycle. The stall, busy and redirect checks are taken on the falling edge just after the rising edge that should change them.

// File: rtl/loopc_pkg.sv
package loopc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAP  = 2'd1,
    ST_REP  = 2'd2,
    ST_WAIT = 2'd3
  } lc_state_e;
endpackage

// File: rtl/loopc_mem.sv
module loopc_mem #(
  parameter int IW = 16,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [NW-1:0] wr_addr,
  input  logic [IW-1:0] wr_data,
  input  logic [NW-1:0] rd_addr,
  output logic [IW-1:0] rd_data
);
  localparam int SLOTS = 1 << NW;

  logic [IW-1:0] mem [SLOTS];

  // single write port, registered read: maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/loopc_seq.sv
module loopc_seq
  import loopc_pkg::*;
#(
  parameter int AW = 12,
  parameter int NW = 4,
  parameter int KW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          loop_start_i,
  input  logic [NW-1:0] loop_n_i,
  input  logic [KW-1:0] loop_k_i,
  input  logic [KW-1:0] loop_count_i,
  input  logic          out_last,
  output logic          take,
  output logic          take_last,
  output logic          wr_en,
  output logic [NW-1:0] wr_ptr,
  output logic [NW-1:0] rd_ptr,
  output logic          iss,
  output logic          iss_last,
  output logic          busy_o,
  output logic          stall_o,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_addr_o
);
  localparam logic [KW-1:0] K_ZERO = '0;
  localparam logic [KW-1:0] K_ONE  = KW'(1);
  localparam logic [NW-1:0] N_ZERO = '0;
  localparam logic [NW-1:0] N_ONE  = NW'(1);
  localparam logic [AW-1:0] A_ONE  = AW'(1);

  lc_state_e     state;
  logic [NW-1:0] cnt_q;
  logic [KW-1:0] kk_q;
  logic [KW-1:0] pr_q;
  logic [AW-1:0] last_addr_q;
  logic          rep_q;
  logic [KW-1:0] eff_k;
  logic [KW-1:0] eff_k1;
  logic          cap_fire;
  logic          cap_end;
  logic          pass_end;

  always_comb begin
    eff_k     = (loop_k_i != K_ZERO) ? loop_k_i : loop_count_i;
    eff_k1    = (eff_k == K_ZERO) ? K_ONE : eff_k;
    take      = fetch_valid_i && ((state == ST_IDLE) || (state == ST_CAP));
    cap_fire  = take && (state == ST_CAP);
    cap_end   = cap_fire && (wr_ptr == cnt_q - N_ONE);
    take_last = cap_end && (kk_q == K_ONE);
    wr_en     = cap_fire;
    iss       = (state == ST_REP);
    pass_end  = (rd_ptr == cnt_q - N_ONE);
    iss_last  = iss && pass_end && (pr_q == K_ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      cnt_q           <= N_ZERO;
      kk_q            <= K_ONE;
      pr_q            <= K_ZERO;
      last_addr_q     <= '0;
      rep_q           <= 1'b0;
      wr_ptr          <= N_ZERO;
      rd_ptr          <= N_ZERO;
      busy_o          <= 1'b0;
      stall_o         <= 1'b0;
      redirect_o      <= 1'b0;
      redirect_addr_o <= '0;
    end else begin
      redirect_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (loop_start_i) begin
            kk_q <= eff_k1;
            if (loop_n_i != N_ZERO) begin
              cnt_q  <= loop_n_i;
              wr_ptr <= N_ZERO;
              rep_q  <= (eff_k1 != K_ONE);
              busy_o <= 1'b1;
              state  <= ST_CAP;
            end else if (cnt_q != N_ZERO) begin
              pr_q    <= eff_k1;
              rd_ptr  <= N_ZERO;
              rep_q   <= 1'b0;
              busy_o  <= 1'b1;
              stall_o <= 1'b1;
              state   <= ST_REP;
            end
          end
        end
        ST_CAP: begin
          if (cap_fire) begin
            wr_ptr      <= wr_ptr + N_ONE;
            last_addr_q <= fetch_addr_i;
            if (cap_end) begin
              if (kk_q != K_ONE) begin
                pr_q    <= kk_q - K_ONE;
                rd_ptr  <= N_ZERO;
                stall_o <= 1'b1;
                state   <= ST_REP;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
        end
        ST_REP: begin
          if (pass_end) begin
            rd_ptr <= N_ZERO;
            pr_q   <= pr_q - K_ONE;
            if (pr_q == K_ONE) state <= ST_WAIT;
          end else begin
            rd_ptr <= rd_ptr + N_ONE;
          end
        end
        ST_WAIT: begin
          if (out_last) begin
            busy_o          <= 1'b0;
            stall_o         <= 1'b0;
            redirect_o      <= rep_q;
            redirect_addr_o <= last_addr_q + A_ONE;
            state           <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: fetch is never consumed while stalled
  a_r3_no_take_when_stalled: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> !take);

  // R7: stall only ever occurs inside a busy loop
  a_r7_stall_within_busy: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> busy_o);

  // R6: the redirect pulse marks the end of the loop
  a_r6_redirect_at_end: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (!busy_o && !stall_o));

  // R10: writes stay inside the loaded word count
  a_r10_write_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_ptr < cnt_q));

  // R8: a strobe during a loop leaves the stored count alone
  a_r8_strobe_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy_o && loop_start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/loopc_out.sv
module loopc_out #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          take_last,
  input  logic [IW-1:0] fetch_data_i,
  input  logic          iss,
  input  logic          iss_last,
  input  logic [IW-1:0] rd_data,
  output logic [IW-1:0] instr_o,
  output logic          instr_valid_o,
  output logic          out_last
);
  logic rd_v;
  logic rd_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v          <= 1'b0;
      rd_l          <= 1'b0;
      instr_o       <= '0;
      instr_valid_o <= 1'b0;
      out_last      <= 1'b0;
    end else begin
      rd_v <= iss;
      rd_l <= iss_last;
      if (rd_v) begin
        instr_o       <= rd_data;
        instr_valid_o <= 1'b1;
        out_last      <= rd_l;
      end else if (take) begin
        instr_o       <= fetch_data_i;
        instr_valid_o <= 1'b1;
        out_last      <= take_last;
      end else begin
        instr_valid_o <= 1'b0;
        out_last      <= 1'b0;
      end
    end
  end

  // R3: replayed and fetched words never compete for the output
  a_r3_single_source: assert property (@(posedge clk) disable iff (rst)
    !(rd_v && take));

  // R1: an accepted fetch word is issued on the next cycle
  a_r1_take_latency: assert property (@(posedge clk) disable iff (rst)
    take |=> instr_valid_o);
endmodule

// File: rtl/loop_cache_ctrl.sv
module loop_cache_ctrl #(
  parameter int IW = 16,
  parameter int AW = 12,
  parameter int NW = 4,
  parameter int KW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic [IW-1:0] fetch_data_i,
  input  logic          loop_start_i,
  input  logic [NW-1:0] loop_n_i,
  input  logic [KW-1:0] loop_k_i,
  input  logic [KW-1:0] loop_count_i,
  output logic [IW-1:0] instr_o,
  output logic          instr_valid_o,
  output logic          stall_o,
  output logic          busy_o,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_addr_o
);
  logic          take;
  logic          take_last;
  logic          wr_en;
  logic [NW-1:0] wr_ptr;
  logic [NW-1:0] rd_ptr;
  logic          iss;
  logic          iss_last;
  logic          out_last;
  logic [IW-1:0] rd_data;

  loopc_seq #(.AW(AW), .NW(NW), .KW(KW)) u_seq (
    .clk             (clk),
    .rst             (rst),
    .fetch_valid_i   (fetch_valid_i),
    .fetch_addr_i    (fetch_addr_i),
    .loop_start_i    (loop_start_i),
    .loop_n_i        (loop_n_i),
    .loop_k_i        (loop_k_i),
    .loop_count_i    (loop_count_i),
    .out_last        (out_last),
    .take            (take),
    .take_last       (take_last),
    .wr_en           (wr_en),
    .wr_ptr          (wr_ptr),
    .rd_ptr          (rd_ptr),
    .iss             (iss),
    .iss_last        (iss_last),
    .busy_o          (busy_o),
    .stall_o         (stall_o),
    .redirect_o      (redirect_o),
    .redirect_addr_o (redirect_addr_o)
  );

  loopc_mem #(.IW(IW), .NW(NW)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_ptr),
    .wr_data (fetch_data_i),
    .rd_addr (rd_ptr),
    .rd_data (rd_data)
  );

  loopc_out #(.IW(IW)) u_out (
    .clk           (clk),
    .rst           (rst),
    .take          (take),
    .take_last     (take_last),
    .fetch_data_i  (fetch_data_i),
    .iss           (iss),
    .iss_last      (iss_last),
    .rd_data       (rd_data),
    .instr_o       (instr_o),
    .instr_valid_o (instr_valid_o),
    .out_last      (out_last)
  );
endmodule

// File: tb/test_loop_cache_ctrl.sv
`timescale 1ns/1ps
module test_loop_cache_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fv = 1'b0;
  logic [11:0] fa = '0;
  logic [15:0] fd = '0;
  logic        ls = 1'b0;
  logic [3:0]  ln = '0;
  logic [6:0]  lk = '0;
  logic [6:0]  lc = '0;
  logic [15:0] instr_o;
  logic        instr_valid_o, stall_o, busy_o, redirect_o;
  logic [11:0] redirect_addr_o;

  int errors = 0;
  int checks = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  loop_cache_ctrl i_loop_cache_ctrl (
    .clk(clk), .rst(rst), .fetch_valid_i(fv), .fetch_addr_i(fa),
    .fetch_data_i(fd), .loop_start_i(ls), .loop_n_i(ln), .loop_k_i(lk),
    .loop_count_i(lc), .instr_o(instr_o), .instr_valid_o(instr_valid_o),
    .stall_o(stall_o), .busy_o(busy_o), .redirect_o(redirect_o),
    .redirect_addr_o(redirect_addr_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] d, input string t);
    exp_q.push_back(d);
    tag_q.push_back(t);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && instr_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected word", int'(instr_o), 0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(instr_o == e, t, int'(instr_o), int'(e));
      end
    end
  end

  task automatic fetch_word(input logic [11:0] a, input logic [15:0] d, input string t);
    while (stall_o) @(negedge clk);
    fv = 1'b1; fa = a; fd = d;
    push(d, t);
    @(negedge clk);
    fv = 1'b0;
  endtask

  task automatic strobe(input logic [3:0] n, input logic [6:0] k,
                        input bit eb, input bit es, input string t);
    ls = 1'b1; ln = n; lk = k;
    @(negedge clk);
    ls = 1'b0;
    chk(busy_o == eb, {t, " busy after strobe"}, int'(busy_o), int'(eb));
    chk(stall_o == es, {t, " stall after strobe"}, int'(stall_o), int'(es));
  endtask

  task automatic wait_idle(input bit es, input bit er, input logic [11:0] ea, input string t);
    bit pv;
    pv = 1'b0;
    chk(stall_o == es, {t, " stall at entry"}, int'(stall_o), int'(es));
    while (busy_o) begin
      pv = instr_valid_o;
      @(negedge clk);
    end
    chk(pv == 1'b1, "R7 busy falls after last word", int'(pv), 1);
    chk(stall_o == 1'b0, "R7 stall falls with busy", int'(stall_o), 0);
    chk(redirect_o == er, {t, " redirect"}, int'(redirect_o), int'(er));
    if (er) chk(redirect_addr_o == ea, "R6 redirect address", int'(redirect_addr_o), int'(ea));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    lc = 7'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 0 && stall_o == 0 && instr_valid_o == 0 && redirect_o == 0,
        "reset state", int'({busy_o, stall_o, instr_valid_o, redirect_o}), 0);

    // R5: redo with nothing stored does nothing
    strobe(4'd0, 7'd2, 1'b0, 1'b0, "R5 empty redo");
    repeat (4) @(negedge clk);

    // R1: idle pass-through
    for (int i = 0; i < 3; i++) fetch_word(12'h010 + 12'(i), 16'h1100 + 16'(i), "R1 pass");
    repeat (3) @(negedge clk);

    // R2 R3 R6: N=3 K=4, junk during stall ignored
    strobe(4'd3, 7'd4, 1'b1, 1'b0, "R7 load");
    for (int i = 0; i < 3; i++) fetch_word(12'h100 + 12'(i), 16'hA000 + 16'(i), "R2 capture");
    for (int p = 0; p < 3; p++)
      for (int i = 0; i < 3; i++) push(16'hA000 + 16'(i), "R3 replay");
    chk(stall_o == 1'b1, "R3 stall after last capture", int'(stall_o), 1);
    fv = 1'b1; fa = 12'hFFF; fd = 16'hDEAD;
    repeat (3) @(negedge clk);
    fv = 1'b0;
    wait_idle(1'b1, 1'b1, 12'h103, "R6 N3K4");

    // R4: K=0 takes loop_count_i=2, N=2
    lc = 7'd2;
    strobe(4'd2, 7'd0, 1'b1, 1'b0, "R4 load");
    for (int i = 0; i < 2; i++) fetch_word(12'h200 + 12'(i), 16'hB000 + 16'(i), "R4 capture");
    for (int i = 0; i < 2; i++) push(16'hB000 + 16'(i), "R4 replay");
    wait_idle(1'b1, 1'b1, 12'h202, "R4 N2K0");

    // R5: redo K=3 replays the two stored words three times
    strobe(4'd0, 7'd3, 1'b1, 1'b1, "R5 redo");
    for (int p = 0; p < 3; p++)
      for (int i = 0; i < 2; i++) push(16'hB000 + 16'(i), "R5 redo word");
    wait_idle(1'b1, 1'b0, 12'h000, "R5 redo");

    // R9: K=1 single pass, no stall, no redirect
    strobe(4'd5, 7'd1, 1'b1, 1'b0, "R9 load");
    for (int i = 0; i < 5; i++) fetch_word(12'h300 + 12'(i), 16'hC000 + 16'(i), "R9 capture");
    wait_idle(1'b0, 1'b0, 12'h000, "R9 K1");

    // R10: full 15-word loop, K=2
    strobe(4'd15, 7'd2, 1'b1, 1'b0, "R10 load");
    for (int i = 0; i < 15; i++) fetch_word(12'h400 + 12'(i), 16'hD000 + 16'(i), "R10 capture");
    for (int i = 0; i < 15; i++) push(16'hD000 + 16'(i), "R10 replay");
    wait_idle(1'b1, 1'b1, 12'h40F, "R10 N15");

    // R8: strobe during replay ignored; later redo still sees two words
    strobe(4'd2, 7'd3, 1'b1, 1'b0, "R8 load");
    for (int i = 0; i < 2; i++) fetch_word(12'h500 + 12'(i), 16'hE000 + 16'(i), "R8 capture");
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 2; i++) push(16'hE000 + 16'(i), "R8 replay");
    ls = 1'b1; ln = 4'd1; lk = 7'd5;
    @(negedge clk);
    ls = 1'b0;
    wait_idle(1'b1, 1'b1, 12'h502, "R8 N2K3");
    strobe(4'd0, 7'd1, 1'b1, 1'b1, "R8 redo");
    for (int i = 0; i < 2; i++) push(16'hE000 + 16'(i), "R8 stored count kept");
    wait_idle(1'b1, 1'b0, 12'h000, "R8 redo");

    // R4: K=0 with loop_count_i=0 gives one pass
    lc = 7'd0;
    strobe(4'd3, 7'd0, 1'b1, 1'b0, "R4 zero count");
    for (int i = 0; i < 3; i++) fetch_word(12'h600 + 12'(i), 16'hF000 + 16'(i), "R4 one pass");
    wait_idle(1'b0, 1'b0, 12'h000, "R4 zero count");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected words issued", exp_q.size(), 0);
    finish_run();
  end
endmodule